// File: doc/BRIEF.md
# Cache Set Status Keeper with Lock-Aware Pseudo-LRU

This unit keeps the per-set bookkeeping that a set-associative cache bank needs next to its tag store. For each set it holds one dirty flag and one pinned flag per way, plus a binary pseudo-LRU tree of ways-1 bits. Ordinary traffic from the tag side (reads, writes and pin commands) is posted into a small in-order queue and applied to the array one entry per cycle. Miss handling and line installs arrive on a separate bypass port that reaches the array directly and always takes the array before the queue.

A miss lookup reads the addressed set and, one cycle later, returns a replacement way chosen by walking the pseudo-LRU tree while steering around pinned ways, together with the dirty flag of that way so the caller knows whether a write-back is needed. If every way of the set is pinned, a no-victim flag is raised instead. An install marks the fresh line clean and records it as recently used. Tag comparison and data movement live elsewhere.

Top module: `cache_status_unit`

## Requirements
- R1: After synchronous reset, req_ready is 1, vict_valid is 0, and every dirty flag, pinned flag and tree bit is 0, so a lookup on any set returns way 0, clean, with vict_none 0.
- R2: A queued write (req_op 1) sets the dirty flag of its way; a later lookup that chooses that way reports vict_dirty 1.
- R3: A queued pin command (req_op 2) sets the pinned flag of its way; a lookup never returns a pinned way.
- R4: A queued read (req_op 0) or write updates its set's tree: node k has children 2k+1 (lower way indices) and 2k+2; a node value 1 steers replacement to its right child; an access sets every node on its path to point away from the accessed way, the most significant way-index bit choosing at the root. Lookup follows the steered child unless that subtree is fully pinned.
- R5: Queued requests are applied in arrival order, one per cycle, starting the cycle after acceptance; req_ready is 0 exactly when QUEUE_DEPTH entries are waiting, and a request offered while req_ready is 0 is dropped.
- R6: In a cycle with byp_valid 1 no queued entry is applied; queued entries wait until the bypass port is idle.
- R7: A lookup (byp_op 0) raises vict_valid for exactly the following cycle, with vict_way, vict_dirty and vict_none reflecting the set as it stood in the lookup cycle.
- R8: When every way of the looked-up set is pinned, vict_none is 1 and vict_dirty is 0.
- R9: An install (byp_op 1) clears the dirty flag of its way and updates the tree as an access to that way does.
- R10: A pin command and a lookup leave the tree bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Queued request offered |
| req_ready | output | 1 | Queue has room; request accepted when both high |
| req_op | input | 2 | 0 read, 1 write, 2 pin, 3 reserved (no effect) |
| req_set | input | log2(NUM_SETS) | Set index of queued request |
| req_way | input | log2(NUM_WAYS) | Way of queued request |
| byp_valid | input | 1 | Bypass access this cycle |
| byp_op | input | 1 | 0 miss lookup, 1 install |
| byp_set | input | log2(NUM_SETS) | Set index of bypass access |
| byp_way | input | log2(NUM_WAYS) | Way being installed |
| vict_valid | output | 1 | Lookup result present |
| vict_way | output | log2(NUM_WAYS) | Chosen replacement way |
| vict_dirty | output | 1 | Chosen way holds modified data, write-back needed |
| vict_none | output | 1 | All ways of the set pinned, nothing to replace |

## Verification
The collision that matters is a bypass access landing in the same cycle as a queued entry waiting at the head of the queue. The bench provokes it by holding the bypass port busy with lookups while writes and reads are posted, so that the lookups must still report the set as it was before the posted work, and the queue must fill and drop req_ready. Once the bypass port is released, a follow-up lookup shows that the held entries were applied afterwards and in arrival order, and a behavioural model of sets, queue and tree is compared against the outputs every cycle under mixed random traffic.

// File: rtl/status_pkg.sv
package status_pkg;

    typedef enum logic [1:0] {
        SOP_READ  = 2'd0,
        SOP_WRITE = 2'd1,
        SOP_PIN   = 2'd2,
        SOP_RSVD  = 2'd3
    } sop_e;

    typedef enum logic {
        BYP_LOOKUP  = 1'b0,
        BYP_INSTALL = 1'b1
    } byp_op_e;

    typedef enum logic [2:0] {
        UK_NONE    = 3'd0,
        UK_READ    = 3'd1,
        UK_WRITE   = 3'd2,
        UK_PIN     = 3'd3,
        UK_INSTALL = 3'd4
    } upd_kind_e;

    function automatic upd_kind_e to_upd(sop_e op);
        case (op)
            SOP_READ:  return UK_READ;
            SOP_WRITE: return UK_WRITE;
            SOP_PIN:   return UK_PIN;
            default:   return UK_NONE;
        endcase
    endfunction

    function automatic logic upd_touches_tree(upd_kind_e k);
        return (k == UK_READ) || (k == UK_WRITE) || (k == UK_INSTALL);
    endfunction

endpackage

// File: rtl/status_req_fifo.sv
module status_req_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;

    function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty = (count == '0);
    assign full  = (count == CNT_W'(DEPTH));
    assign dout  = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                mem[wr_ptr] <= din;
                wr_ptr      <= bump(wr_ptr);
            end
            if (pop) begin
                rd_ptr <= bump(rd_ptr);
            end
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R5: occupancy only moves when an entry enters or leaves
    assert_fifo_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!push && !pop) |=> $stable(count));

    // R5: never pops from an empty queue
    assert_no_underflow_R5: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);

endmodule

// File: rtl/status_array.sv
module status_array
    import status_pkg::*;
#(
    parameter int NUM_SETS = 16,
    parameter int NUM_WAYS = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  upd_kind_e                   upd_kind,
    input  logic [$clog2(NUM_SETS)-1:0] upd_set,
    input  logic [$clog2(NUM_WAYS)-1:0] upd_way,
    input  logic [$clog2(NUM_SETS)-1:0] rd_set,
    output logic [NUM_WAYS-1:0]         rd_dirty,
    output logic [NUM_WAYS-1:0]         rd_pinned,
    output logic [NUM_WAYS-2:0]         rd_tree
);
    localparam int WAY_W = $clog2(NUM_WAYS);
    localparam int LVLS  = WAY_W;

    logic [NUM_WAYS-1:0] dirty_q  [NUM_SETS];
    logic [NUM_WAYS-1:0] pinned_q [NUM_SETS];
    logic [NUM_WAYS-2:0] tree_q   [NUM_SETS];

    function automatic logic [NUM_WAYS-2:0] touch(logic [NUM_WAYS-2:0] t,
                                                  logic [WAY_W-1:0] w);
        logic [NUM_WAYS-2:0] r;
        int node;
        logic b;
        r    = t;
        node = 0;
        for (int l = 0; l < LVLS; l++) begin
            b       = w[LVLS-1-l];
            r[node] = ~b;
            node    = 2 * node + 1 + (b ? 1 : 0);
        end
        return r;
    endfunction

    assign rd_dirty  = dirty_q[rd_set];
    assign rd_pinned = pinned_q[rd_set];
    assign rd_tree   = tree_q[rd_set];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NUM_SETS; s++) begin
                dirty_q[s]  <= '0;
                pinned_q[s] <= '0;
                tree_q[s]   <= '0;
            end
        end else begin
            if (upd_touches_tree(upd_kind)) begin
                tree_q[upd_set] <= touch(tree_q[upd_set], upd_way);
            end
            case (upd_kind)
                UK_WRITE:   dirty_q[upd_set][upd_way]  <= 1'b1;
                UK_INSTALL: dirty_q[upd_set][upd_way]  <= 1'b0;
                UK_PIN:     pinned_q[upd_set][upd_way] <= 1'b1;
                default: ;
            endcase
        end
    end

    // R2: a write leaves its way marked dirty
    assert_write_marks_R2: assert property (@(posedge clk) disable iff (rst)
        (upd_kind == UK_WRITE) |=> dirty_q[$past(upd_set)][$past(upd_way)]);

    // R9: an install leaves its way clean
    assert_install_clean_R9: assert property (@(posedge clk) disable iff (rst)
        (upd_kind == UK_INSTALL) |=> !dirty_q[$past(upd_set)][$past(upd_way)]);

    // R10: pinning does not disturb the replacement tree
    assert_pin_keeps_tree_R10: assert property (@(posedge clk) disable iff (rst)
        (upd_kind == UK_PIN) |=> (tree_q[$past(upd_set)] == $past(tree_q[upd_set])));

endmodule

// File: rtl/status_victim_pick.sv
module status_victim_pick #(
    parameter int NUM_WAYS = 4
) (
    input  logic [NUM_WAYS-1:0]         dirty_row,
    input  logic [NUM_WAYS-1:0]         pinned_row,
    input  logic [NUM_WAYS-2:0]         tree_row,
    output logic [$clog2(NUM_WAYS)-1:0] way,
    output logic                        dirty,
    output logic                        none
);
    localparam int WAY_W = $clog2(NUM_WAYS);

    logic [NUM_WAYS-1:0] free_row;
    assign free_row = ~pinned_row;

    always_comb begin
        int  lo;
        int  node;
        int  half;
        logic lf, rf, go_right;
        lo   = 0;
        node = 0;
        for (int l = 0; l < WAY_W; l++) begin
            half = NUM_WAYS >> (l + 1);
            lf   = 1'b0;
            rf   = 1'b0;
            for (int k = 0; k < NUM_WAYS; k++) begin
                if (k >= lo && k < lo + half)              lf = lf | free_row[k];
                if (k >= lo + half && k < lo + 2 * half)   rf = rf | free_row[k];
            end
            go_right = tree_row[node] ? rf : !lf;
            if (go_right) lo = lo + half;
            node = 2 * node + 1 + (go_right ? 1 : 0);
        end
        way   = WAY_W'(lo);
        none  = ~|free_row;
        dirty = dirty_row[way] & ~none;
    end

endmodule

// File: rtl/cache_status_unit.sv
module cache_status_unit
    import status_pkg::*;
#(
    parameter int NUM_SETS    = 16,
    parameter int NUM_WAYS    = 4,
    parameter int QUEUE_DEPTH = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        req_valid,
    output logic                        req_ready,
    input  logic [1:0]                  req_op,
    input  logic [$clog2(NUM_SETS)-1:0] req_set,
    input  logic [$clog2(NUM_WAYS)-1:0] req_way,
    input  logic                        byp_valid,
    input  logic                        byp_op,
    input  logic [$clog2(NUM_SETS)-1:0] byp_set,
    input  logic [$clog2(NUM_WAYS)-1:0] byp_way,
    output logic                        vict_valid,
    output logic [$clog2(NUM_WAYS)-1:0] vict_way,
    output logic                        vict_dirty,
    output logic                        vict_none
);
    localparam int SET_W = $clog2(NUM_SETS);
    localparam int WAY_W = $clog2(NUM_WAYS);

    typedef struct packed {
        logic [1:0]       op;
        logic [SET_W-1:0] idx;
        logic [WAY_W-1:0] way;
    } qent_t;

    localparam int QENT_W = $bits(qent_t);

    qent_t               q_in, q_head;
    logic                q_push, q_pop, q_empty, q_full;
    upd_kind_e           upd_kind;
    logic [SET_W-1:0]    upd_set;
    logic [WAY_W-1:0]    upd_way;
    logic [NUM_WAYS-1:0] row_dirty, row_pinned;
    logic [NUM_WAYS-2:0] row_tree;
    logic [WAY_W-1:0]    pick_way;
    logic                pick_dirty, pick_none;
    logic                is_lookup;

    assign q_in      = '{op: req_op, idx: req_set, way: req_way};
    assign req_ready = !q_full;
    assign q_push    = req_valid && !q_full;
    assign q_pop     = !q_empty && !byp_valid;
    assign is_lookup = byp_valid && (byp_op_e'(byp_op) == BYP_LOOKUP);

    status_req_fifo #(
        .WIDTH (QENT_W),
        .DEPTH (QUEUE_DEPTH)
    ) u_queue (
        .clk   (clk),
        .rst   (rst),
        .push  (q_push),
        .din   (q_in),
        .pop   (q_pop),
        .dout  (q_head),
        .empty (q_empty),
        .full  (q_full)
    );

    always_comb begin
        upd_kind = UK_NONE;
        upd_set  = q_head.idx;
        upd_way  = q_head.way;
        if (byp_valid) begin
            upd_set = byp_set;
            upd_way = byp_way;
            if (byp_op_e'(byp_op) == BYP_INSTALL) upd_kind = UK_INSTALL;
        end else if (!q_empty) begin
            upd_kind = to_upd(sop_e'(q_head.op));
        end
    end

    status_array #(
        .NUM_SETS (NUM_SETS),
        .NUM_WAYS (NUM_WAYS)
    ) u_array (
        .clk       (clk),
        .rst       (rst),
        .upd_kind  (upd_kind),
        .upd_set   (upd_set),
        .upd_way   (upd_way),
        .rd_set    (byp_set),
        .rd_dirty  (row_dirty),
        .rd_pinned (row_pinned),
        .rd_tree   (row_tree)
    );

    status_victim_pick #(
        .NUM_WAYS (NUM_WAYS)
    ) u_pick (
        .dirty_row  (row_dirty),
        .pinned_row (row_pinned),
        .tree_row   (row_tree),
        .way        (pick_way),
        .dirty      (pick_dirty),
        .none       (pick_none)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vict_valid <= 1'b0;
            vict_way   <= '0;
            vict_dirty <= 1'b0;
            vict_none  <= 1'b0;
        end else begin
            vict_valid <= is_lookup;
            if (is_lookup) begin
                vict_way   <= pick_way;
                vict_dirty <= pick_dirty;
                vict_none  <= pick_none;
            end
        end
    end

    // R3: the picked way is never a pinned one
    assert_victim_unpinned_R3: assert property (@(posedge clk) disable iff (rst)
        (is_lookup && !pick_none) |-> !row_pinned[pick_way]);

    // R6: a busy bypass port keeps queued work waiting
    assert_queue_held_R6: assert property (@(posedge clk) disable iff (rst)
        (byp_valid && !q_empty) |=> !q_empty);

    // R7: a result appears only after a lookup
    assert_result_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        vict_valid |-> ($past(byp_valid) && !$past(byp_op)));

    // R8: no-victim reported only for a fully pinned set, and never dirty
    assert_none_all_pinned_R8: assert property (@(posedge clk) disable iff (rst)
        (vict_valid && vict_none) |-> ((&$past(row_pinned)) && !vict_dirty));

endmodule

// File: tb/cache_status_unit_bench.sv
module cache_status_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 16;
    localparam int NW = 4;
    localparam int QD = 4;
    localparam int WATCHDOG = 100000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [1:0] req_op = 2'd0;
    logic [3:0] req_set = 4'd0;
    logic [1:0] req_way = 2'd0;
    logic       byp_valid = 1'b0;
    logic       byp_op = 1'b0;
    logic [3:0] byp_set = 4'd0;
    logic [1:0] byp_way = 2'd0;
    logic       vict_valid;
    logic [1:0] vict_way;
    logic       vict_dirty;
    logic       vict_none;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cache_status_unit #(
        .NUM_SETS    (NS),
        .NUM_WAYS    (NW),
        .QUEUE_DEPTH (QD)
    ) u_cache_status_unit (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_op     (req_op),
        .req_set    (req_set),
        .req_way    (req_way),
        .byp_valid  (byp_valid),
        .byp_op     (byp_op),
        .byp_set    (byp_set),
        .byp_way    (byp_way),
        .vict_valid (vict_valid),
        .vict_way   (vict_way),
        .vict_dirty (vict_dirty),
        .vict_none  (vict_none)
    );

    int nchecks = 0;
    int nfail   = 0;
    bit done    = 0;

    // behavioural reference state
    bit [3:0] m_dirty [NS];
    bit [3:0] m_pin   [NS];
    bit [2:0] m_tree  [NS];
    int       m_q[$];
    bit       e_valid = 0;
    int       e_way = 0;
    bit       e_dirty = 0;
    bit       e_none = 0;

    task automatic chk(bit ok, string tag, int act, int exp);
        nchecks++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic void m_touch(int s, int w);
        bit hi = w[1];
        bit lo = w[0];
        m_tree[s][0] = !hi;
        if (!hi) m_tree[s][1] = !lo;
        else     m_tree[s][2] = !lo;
    endfunction

    function automatic void m_pick(int s);
        bit [3:0] fr = ~m_pin[s];
        bit lf = fr[0] | fr[1];
        bit rf = fr[2] | fr[3];
        bit go_r, pref;
        int base;
        e_none = (fr == 4'b0000);
        go_r = m_tree[s][0] ? rf : !lf;
        base = go_r ? 2 : 0;
        pref = go_r ? m_tree[s][2] : m_tree[s][1];
        if (pref) e_way = fr[base+1] ? base + 1 : base;
        else      e_way = fr[base]   ? base     : base + 1;
        e_dirty = e_none ? 1'b0 : m_dirty[s][e_way];
    endfunction

    function automatic void m_apply(int e);
        int op = e / 256;
        int s  = (e / 16) % 16;
        int w  = e % 16;
        case (op)
            0: m_touch(s, w);
            1: begin m_touch(s, w); m_dirty[s][w] = 1'b1; end
            2: m_pin[s][w] = 1'b1;
            default: ;
        endcase
    endfunction

    task automatic cycle();
        bit room = (m_q.size() < QD);
        int ent = int'(req_op) * 256 + int'(req_set) * 16 + int'(req_way);
        @(posedge clk);
        e_valid = 0;
        if (byp_valid) begin
            if (!byp_op) begin
                m_pick(int'(byp_set));
                e_valid = 1;
            end else begin
                m_dirty[byp_set][byp_way] = 1'b0;
                m_touch(int'(byp_set), int'(byp_way));
            end
        end else if (m_q.size() > 0) begin
            m_apply(m_q.pop_front());
        end
        if (req_valid && room) m_q.push_back(ent);
        @(negedge clk);
        chk(req_ready == (m_q.size() < QD), "R5 req_ready", int'(req_ready), int'(m_q.size() < QD));
        chk(vict_valid == e_valid, "R7 vict_valid", int'(vict_valid), int'(e_valid));
        if (e_valid) begin
            chk(vict_none == e_none, "R8 vict_none", int'(vict_none), int'(e_none));
            chk(vict_way == 2'(e_way) || e_none, "R3 R4 vict_way", int'(vict_way), e_way);
            chk(vict_dirty == e_dirty, "R2 vict_dirty", int'(vict_dirty), int'(e_dirty));
        end
    endtask

    task automatic post(int op, int s, int w);
        req_valid = 1; req_op = 2'(op); req_set = 4'(s); req_way = 2'(w);
        cycle();
        req_valid = 0;
        cycle();
    endtask

    task automatic look(int s, int ew, bit ed, bit en, string tag);
        byp_valid = 1; byp_op = 0; byp_set = 4'(s);
        cycle();
        byp_valid = 0;
        chk(vict_valid == 1'b1, tag, int'(vict_valid), 1);
        chk(vict_none == en, tag, int'(vict_none), int'(en));
        if (!en) chk(vict_way == 2'(ew), tag, int'(vict_way), ew);
        chk(vict_dirty == ed, tag, int'(vict_dirty), int'(ed));
        cycle();
        chk(vict_valid == 1'b0, "R7 single pulse", int'(vict_valid), 0);
    endtask

    task automatic install(int s, int w);
        byp_valid = 1; byp_op = 1; byp_set = 4'(s); byp_way = 2'(w);
        cycle();
        byp_valid = 0;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
    endtask

    initial begin
        for (int i = 0; i < WATCHDOG; i++) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
            summary();
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < NS; s++) begin
            m_dirty[s] = '0; m_pin[s] = '0; m_tree[s] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1: reset state
        chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
        chk(vict_valid == 1'b0, "R1 no result after reset", int'(vict_valid), 0);
        look(3, 0, 0, 0, "R1 fresh set");
        look(3, 0, 0, 0, "R10 lookup leaves state");

        // R4: tree walk on set 3
        post(0, 3, 0);
        look(3, 2, 0, 0, "R4 after read way0");
        post(1, 3, 2);
        look(3, 1, 0, 0, "R4 after write way2");
        post(1, 3, 1);
        post(0, 3, 3);
        look(3, 0, 0, 0, "R4 tree back to way0");
        post(0, 3, 0);
        look(3, 2, 1, 0, "R2 dirty victim way2");
        // R3 / R10: pins steer around and keep the tree
        post(2, 3, 2);
        look(3, 3, 0, 0, "R3 skip pinned way2");
        post(2, 3, 3);
        look(3, 1, 1, 0, "R3 right side pinned");
        post(2, 3, 0);
        post(2, 3, 1);
        look(3, 0, 0, 1, "R8 all pinned");

        // R6: bypass holds a posted write
        req_valid = 1; req_op = 2'd1; req_set = 4'd5; req_way = 2'd0;
        byp_valid = 1; byp_op = 0; byp_set = 4'd5;
        cycle();
        req_valid = 0;
        chk(vict_way == 2'd0 && !vict_dirty, "R6 first lookup pre-write", int'(vict_way), 0);
        cycle();
        chk(vict_way == 2'd0 && !vict_dirty, "R6 queued write still waiting", int'(vict_way), 0);
        byp_valid = 0;
        cycle();
        look(5, 2, 0, 0, "R6 write applied after release");

        // R5: fill the queue behind a busy bypass, then check order
        byp_valid = 1; byp_op = 0; byp_set = 4'd9;
        req_valid = 1;
        req_op = 2'd0; req_set = 4'd11; req_way = 2'd0; cycle();
        req_way = 2'd2; cycle();
        req_set = 4'd12; req_way = 2'd0; cycle();
        req_way = 2'd1; cycle();
        chk(req_ready == 1'b0, "R5 full queue", int'(req_ready), 0);
        req_set = 4'd13; req_way = 2'd3; cycle();   // dropped
        req_valid = 0;
        byp_valid = 0;
        repeat (QD) cycle();
        chk(req_ready == 1'b1, "R5 drained", int'(req_ready), 1);
        look(11, 1, 0, 0, "R5 arrival order");
        look(12, 2, 0, 0, "R5 second set order");
        look(13, 0, 0, 0, "R5 dropped request had no effect");

        // R9: install cleans and touches
        post(1, 7, 0);
        post(0, 7, 2);
        post(0, 7, 1);
        post(0, 7, 3);
        look(7, 0, 1, 0, "R9 dirty before install");
        install(7, 0);
        cycle();
        look(7, 2, 0, 0, "R9 install touched tree");
        post(0, 7, 2);
        post(0, 7, 1);
        post(0, 7, 3);
        look(7, 0, 0, 0, "R9 installed way clean");

        // mixed traffic against the model
        for (int i = 0; i < 4000; i++) begin
            int r = int'($urandom % 16);
            req_valid = ($urandom % 2) == 0;
            req_op    = (r == 0) ? 2'd2 : 2'($urandom % 2);
            req_set   = 4'($urandom % 4);
            req_way   = 2'($urandom % 4);
            byp_valid = ($urandom % 3) == 0;
            byp_op    = ($urandom % 4) == 0;
            byp_set   = 4'($urandom % 4);
            byp_way   = 2'($urandom % 4);
            cycle();
        end
        req_valid = 0;
        byp_valid = 0;
        repeat (QD + 2) cycle();

        done = 1;
        summary();
        $finish;
    end

endmodule